// File: doc/BRIEF.md
# I2C Register-Access Target

This block is a bus target for a two-wire open-drain serial bus. It holds a small bank of byte-wide registers and lets a bus controller write one register or read one register per transaction. A fast system clock oversamples both bus lines. The block finds start, repeated-start and stop conditions and answers only to one fixed 7-bit device address. It acknowledges each byte it accepts and shifts read data out most significant bit first. The block only ever pulls the data line low or lets it go. It never drives a high level.

A write transaction sends the device address with direction bit 0, then a register pointer byte, then one data byte. The target acknowledges each of the three bytes, and the controller ends with a stop. A read transaction also starts by writing the pointer. The controller then issues a repeated start and sends the address with direction bit 1. The target acknowledges, drives the selected register's byte, and the controller answers with a not-acknowledge followed by a stop. A separate test port can read and write the register bank directly, without using the bus.

Top module: `i2c_reg_target`

## Requirements
- R1: After reset the data-line pull-down `sda_oe` is 0 and every register reads 0 through the test port.
- R2: A write frame (start, address byte `{DEV_ADDR,0}`, pointer byte, data byte, stop) is acknowledged on each of the three 9th clocks (SDA held low while SCL is high). The data byte is stored in the register the pointer selects.
- R3: A read frame is a pointer write, then a repeated start, then the address byte `{DEV_ADDR,1}`. The target acknowledges it and then presents the selected register on SDA, MSB first, one bit per SCL high phase.
- R4: An address byte whose upper 7 bits differ from `DEV_ADDR` gets no acknowledge, and the rest of that transaction changes no register.
- R5: A stop received before the 8th data bit leaves every register unchanged and returns the target to idle with SDA released.
- R6: A repeated start at any bit position abandons the current byte and restarts address reception. The register pointer keeps its last written value, so a following read returns the register it selects.
- R7: After the 8th read data bit, the target releases SDA for the controller's acknowledge slot. It stays released whether that slot is a NACK or an ACK, until the next start.
- R8: `sda_oe` changes only while SCL is low, as seen after synchronization. Start and stop conditions are therefore never forged by the target.
- R9: Only the low log2(DEPTH) bits of the pointer select a register. With DEPTH=16, pointer 0x13 addresses register 3.
- R10: A test-port write stores `tst_wdata` at `tst_idx` on the next clock, and `tst_rdata` always shows the register at `tst_idx`. A byte preloaded this way is returned by a bus read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled level of the bus clock line |
| sda_i | input | 1 | Sampled level of the bus data line |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| tst_we | input | 1 | Test-port write enable |
| tst_idx | input | log2(DEPTH) | Test-port register index |
| tst_wdata | input | 8 | Test-port write data |
| tst_rdata | output | 8 | Register contents at `tst_idx` |

## Verification
A bus edge passes through two synchronizer flops and a history flop before the state register reacts, so `sda_oe` settles no more than four system cycles after an SCL fall. The bench holds each SCL quarter period for 10 cycles and samples SDA halfway through the high phase, far past that settling point. A bus write lands in the register bank one cycle after the fall that ends the 8th data bit, and `tst_rdata` is combinational. The bench therefore reads the bank only after the closing stop, and checks test-port writes one clock after they are issued. All signals are driven and sampled on the falling system-clock edge.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_PTR,
        ST_PACK,
        ST_WDAT,
        ST_WACK,
        ST_RDAT,
        ST_RACK,
        ST_SKIP
    } tgt_st_e;

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] lvl,
    output logic [LINES-1:0] prv
);

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain_q;
        logic              hist_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= '1;
                hist_q  <= 1'b1;
            end else begin
                chain_q <= {chain_q[STAGES-2:0], raw[g]};
                hist_q  <= chain_q[STAGES-1];
            end
        end

        assign lvl[g] = chain_q[STAGES-1];
        assign prv[g] = hist_q;
    end

endmodule

// File: rtl/i2c_tgt_regfile.sv
module i2c_tgt_regfile #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             a_we,
    input  logic [IDX_W-1:0] a_idx,
    input  logic [WIDTH-1:0] a_wdata,
    output logic [WIDTH-1:0] a_rdata,
    input  logic             b_we,
    input  logic [IDX_W-1:0] b_idx,
    input  logic [WIDTH-1:0] b_wdata,
    output logic [WIDTH-1:0] b_rdata
);

    logic [WIDTH-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (a_we) begin
            mem_q[a_idx] <= a_wdata;
        end else if (b_we) begin
            mem_q[b_idx] <= b_wdata;
        end
    end

    assign a_rdata = mem_q[a_idx];
    assign b_rdata = mem_q[b_idx];

endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h42,
    parameter int         DEPTH    = 16,
    localparam int        IDX_W    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic              tst_we,
    input  logic [IDX_W-1:0]  tst_idx,
    input  logic [BYTE_W-1:0] tst_wdata,
    output logic [BYTE_W-1:0] tst_rdata
);

    localparam logic [3:0] FULL = 4'(BYTE_W);

    typedef struct packed {
        tgt_st_e           st;
        logic [3:0]        bits;
        logic [BYTE_W-1:0] shreg;
        logic [IDX_W-1:0]  ptr;
        logic              rw;
        logic              oe;
    } tgt_t;

    tgt_t q, d;

    logic [1:0] lvl, prv;
    logic scl_s, sda_s, scl_p, sda_p;
    logic rise_ev, fall_ev, start_ev, stop_ev;
    logic reg_we;
    logic [BYTE_W-1:0] reg_rd;
    tgt_st_e cur_st;
    logic [3:0] cur_bits;

    i2c_tgt_sync #(.LINES(2), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   ({scl_i, sda_i}),
        .lvl   (lvl),
        .prv   (prv)
    );

    assign scl_s = lvl[1];
    assign sda_s = lvl[0];
    assign scl_p = prv[1];
    assign sda_p = prv[0];

    assign rise_ev  = scl_s & ~scl_p;
    assign fall_ev  = ~scl_s & scl_p;
    assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;

    i2c_tgt_regfile #(.DEPTH(DEPTH), .WIDTH(BYTE_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_we    (reg_we),
        .a_idx   (q.ptr),
        .a_wdata (q.shreg),
        .a_rdata (reg_rd),
        .b_we    (tst_we),
        .b_idx   (tst_idx),
        .b_wdata (tst_wdata),
        .b_rdata (tst_rdata)
    );

    always_comb begin
        d      = q;
        reg_we = 1'b0;
        if (stop_ev) begin
            d.st   = ST_IDLE;
            d.bits = '0;
            d.oe   = 1'b0;
        end else if (start_ev) begin
            d.st   = ST_ADDR;
            d.bits = '0;
            d.oe   = 1'b0;
        end else begin
            unique case (q.st)
                ST_ADDR, ST_PTR, ST_WDAT: begin
                    if (rise_ev && q.bits < FULL) begin
                        d.shreg = {q.shreg[BYTE_W-2:0], sda_s};
                        d.bits  = q.bits + 4'd1;
                    end else if (fall_ev && q.bits == FULL) begin
                        d.bits = '0;
                        if (q.st == ST_ADDR) begin
                            if (q.shreg[BYTE_W-1:1] == DEV_ADDR) begin
                                d.rw = q.shreg[0];
                                d.oe = 1'b1;
                                d.st = ST_AACK;
                            end else begin
                                d.st = ST_SKIP;
                            end
                        end else if (q.st == ST_PTR) begin
                            d.ptr = q.shreg[IDX_W-1:0];
                            d.oe  = 1'b1;
                            d.st  = ST_PACK;
                        end else begin
                            reg_we = 1'b1;
                            d.oe   = 1'b1;
                            d.st   = ST_WACK;
                        end
                    end
                end
                ST_AACK: begin
                    if (fall_ev) begin
                        d.bits = '0;
                        if (q.rw) begin
                            d.shreg = reg_rd;
                            d.oe    = ~reg_rd[BYTE_W-1];
                            d.st    = ST_RDAT;
                        end else begin
                            d.oe = 1'b0;
                            d.st = ST_PTR;
                        end
                    end
                end
                ST_PACK: begin
                    if (fall_ev) begin
                        d.oe = 1'b0;
                        d.st = ST_WDAT;
                    end
                end
                ST_WACK: begin
                    if (fall_ev) begin
                        d.oe = 1'b0;
                        d.st = ST_SKIP;
                    end
                end
                ST_RDAT: begin
                    if (rise_ev) begin
                        d.bits = q.bits + 4'd1;
                    end else if (fall_ev) begin
                        if (q.bits == FULL) begin
                            d.oe = 1'b0;
                            d.st = ST_RACK;
                        end else begin
                            d.shreg = {q.shreg[BYTE_W-2:0], 1'b0};
                            d.oe    = ~q.shreg[BYTE_W-2];
                        end
                    end
                end
                ST_RACK: begin
                    d.oe = 1'b0;
                    if (rise_ev) d.st = ST_SKIP;
                end
                default: begin
                    d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sda_oe   = q.oe;
    assign cur_st   = q.st;
    assign cur_bits = q.bits;

endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk
    import i2c_tgt_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       sda_oe,
    input logic       scl_s,
    input logic       scl_p,
    input logic       start_ev,
    input logic       stop_ev,
    input logic       rise_ev,
    input tgt_st_e    cur_st,
    input logic [3:0] cur_bits
);

    a_r1_idle_out_of_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!sda_oe && cur_st == ST_IDLE));

    a_r8_sda_steady_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && scl_p) |=> $stable(sda_oe));

    a_r6_start_to_address: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (cur_st == ST_ADDR && cur_bits == 4'd0));

    a_r5_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (cur_st == ST_IDLE && !sda_oe));

    a_r7_release_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_st == ST_RACK && rise_ev) |=> !sda_oe);

    a_r4_silent_when_skipping: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_st == ST_SKIP) |-> !sda_oe);

endmodule

bind i2c_reg_target i2c_reg_target_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sda_oe   (sda_oe),
    .scl_s    (scl_s),
    .scl_p    (scl_p),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .rise_ev  (rise_ev),
    .cur_st   (cur_st),
    .cur_bits (cur_bits)
);

// File: tb/i2c_reg_target_tb.sv
module i2c_reg_target_tb;

    localparam int Q     = 10;
    localparam int DEPTH = 16;
    localparam logic [6:0] DEV = 7'h42;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_low = 1'b0;
    logic tst_we = 1'b0;
    logic [3:0] tst_idx = '0;
    logic [7:0] tst_wdata = '0;
    logic [7:0] tst_rdata;
    logic sda_oe;
    wire  sda_line = !(m_low || sda_oe);

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    i2c_reg_target #(.DEV_ADDR(DEV), .DEPTH(DEPTH)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .tst_we    (tst_we),
        .tst_idx   (tst_idx),
        .tst_wdata (tst_wdata),
        .tst_rdata (tst_rdata)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_low = 1'b0; wait_n(Q);
        scl = 1'b1;   wait_n(Q);
        m_low = 1'b1; wait_n(Q);
        scl = 1'b0;   wait_n(Q);
    endtask

    task automatic bus_stop();
        m_low = 1'b1; wait_n(Q);
        scl = 1'b1;   wait_n(Q);
        m_low = 1'b0; wait_n(2 * Q);
    endtask

    task automatic bus_bit(input bit b, output bit seen);
        wait_n(Q);
        m_low = !b; wait_n(Q);
        scl = 1'b1; wait_n(Q);
        seen = sda_line;
        wait_n(Q);
        scl = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v, output bit acked);
        bit s;
        for (int i = 7; i >= 0; i--) bus_bit(v[i], s);
        bus_bit(1'b1, s);
        acked = !s;
    endtask

    task automatic recv_byte(input bit nack, output logic [7:0] v);
        bit s;
        for (int i = 7; i >= 0; i--) begin
            bus_bit(1'b1, s);
            v[i] = s;
        end
        bus_bit(nack, s);
        wait_n(Q);
    endtask

    task automatic reg_write(input logic [7:0] ptr, input logic [7:0] v);
        bit a0, a1, a2;
        bus_start();
        send_byte({DEV, 1'b0}, a0);
        send_byte(ptr, a1);
        send_byte(v, a2);
        bus_stop();
        check("R2 addr ack", a0, 1);
        check("R2 ptr ack", a1, 1);
        check("R2 data ack", a2, 1);
    endtask

    task automatic reg_read(input logic [7:0] ptr, input bit nack, output logic [7:0] v);
        bit a0, a1, a2;
        bus_start();
        send_byte({DEV, 1'b0}, a0);
        send_byte(ptr, a1);
        bus_start();
        send_byte({DEV, 1'b1}, a2);
        recv_byte(nack, v);
        check("R7 sda released after read", sda_oe, 0);
        bus_stop();
        check("R3 ack chain", {a0, a1, a2}, 3'b111);
    endtask

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 53 + 17) & 255);
    endfunction

    function automatic logic [7:0] peek_pat(input int a);
        return 8'(pat(a) ^ 8'h3C);
    endfunction

    task automatic peek(input int idx, output logic [7:0] v);
        tst_idx = 4'(idx);
        wait_n(1);
        v = tst_rdata;
    endtask

    always @(negedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            finished = 1'b1;
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        bit a, s;
        wait_n(5);
        check("R1 sda_oe in reset", sda_oe, 0);
        rst_n = 1'b1;
        wait_n(5);
        check("R1 sda_oe after reset", sda_oe, 0);
        for (int i = 0; i < DEPTH; i++) begin
            peek(i, v);
            check("R1 register cleared", v, 0);
        end

        // R2 sweep: write every register over the bus
        for (int i = 0; i < DEPTH; i++) reg_write(8'(i), pat(i));
        for (int i = 0; i < DEPTH; i++) begin
            peek(i, v);
            check("R2 stored byte", v, pat(i));
        end

        // R3 sweep: read every register back, alternating final NACK/ACK (R7)
        for (int i = 0; i < DEPTH; i++) begin
            reg_read(8'(i), (i % 2) == 0, v);
            check("R3 read data", v, pat(i));
        end

        // R4: wrong address, no ack, no write
        bus_start();
        send_byte({DEV ^ 7'h01, 1'b0}, a);
        check("R4 no ack on mismatch", a, 0);
        send_byte(8'h05, a);
        check("R4 ptr ignored", a, 0);
        send_byte(8'hEE, a);
        bus_stop();
        peek(5, v);
        check("R4 register untouched", v, pat(5));

        // R5: stop inside the data byte
        bus_start();
        send_byte({DEV, 1'b0}, a);
        send_byte(8'h06, a);
        for (int i = 0; i < 7; i++) bus_bit(1'b0, s);
        bus_stop();
        check("R5 sda released after stop", sda_oe, 0);
        peek(6, v);
        check("R5 no partial commit", v, pat(6));

        // R6: repeated start after 3 data bits, pointer kept
        bus_start();
        send_byte({DEV, 1'b0}, a);
        send_byte(8'h09, a);
        for (int i = 0; i < 3; i++) bus_bit(1'b0, s);
        bus_start();
        send_byte({DEV, 1'b1}, a);
        check("R6 ack after restart", a, 1);
        recv_byte(1'b1, v);
        bus_stop();
        check("R6 pointer kept", v, pat(9));
        peek(9, v);
        check("R6 no write on abort", v, pat(9));

        // R9: pointer aliasing
        reg_write(8'h13, 8'h77);
        peek(3, v);
        check("R9 alias write", v, 8'h77);
        reg_read(8'hF3, 1'b1, v);
        check("R9 alias read", v, 8'h77);

        // R10: test-port writes, then bus reads
        for (int i = 0; i < DEPTH; i++) begin
            tst_idx = 4'(i);
            tst_wdata = peek_pat(i);
            tst_we = 1'b1;
            wait_n(1);
            tst_we = 1'b0;
            wait_n(1);
            check("R10 test write", tst_rdata, peek_pat(i));
        end
        for (int i = 0; i < DEPTH; i += 5) begin
            reg_read(8'(i), 1'b1, v);
            check("R10 bus read of preload", v, peek_pat(i));
        end

        check("R8 idle release", sda_oe, 0);
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule